// File: doc/BRIEF.md
# PWM Timebase Counter with Fractional Prescaler

This block produces the shared time reference for a bank of PWM channels. It takes input ticks from one of two sources: every cycle of the fast bus clock, or a slower reference tick that arrives as a one-cycle enable pulse in the same clock domain. A prescaler divides these ticks by a 10.8 fixed-point ratio. Each prescaler output step advances a free-running up-counter.

The counter's range is a power of two, chosen by a 5-bit resolution field. When the counter wraps, the block emits a one-cycle period strobe for the channels and a raw overflow interrupt pulse. Software can pause the timebase, clear it, and read the live counter value.

Top module: `pwm_timebase`

## Requirements
- R1: When `src_fast` is 1, every clock cycle is an input tick. When it is 0, only cycles with `ref_tick` high are input ticks. While no input tick arrives, the counter holds its value.
- R2: `div_cfg[17:8]` is the integer part I and `div_cfg[7:0]` is the fraction F.
  - Each prescaler period lasts I input ticks, or I+1 input ticks.
  - At the end of every period, F is added into an 8-bit accumulator. If that addition carries, the next period is one tick longer.
  - The first period after reset or clear is I ticks long.
- R3: An integer part of zero acts as one, so the counter never stalls.
- R4: While `pause` is 1, both the counter and the prescaler's phase and accumulator hold. Counting resumes from the held state when `pause` returns to 0.
- R5: While `cnt_clr` is 1, the counter reads zero after the next clock edge. The clear also restarts the prescaler phase and accumulator, and it wins over `pause`.
- R6: With resolution field R, the counter runs from 0 to 2^R-1 and then wraps to 0. Values of R above 20 act as 20. With R=0 the counter stays at 0 and wraps on every prescaler step.
- R7: `period_stb` and `ovf_irq` are one-cycle pulses. They are high in the cycle where the counter first reads 0 after a wrap, and low otherwise.
- R8: If the range is lowered below the current count, the next prescaler step wraps the counter to 0 and pulses the strobes.
- R9: After reset the counter is 0 and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_fast | input | 1 | 1: every clock is a tick; 0: use `ref_tick` |
| ref_tick | input | 1 | Slow reference tick, one-cycle pulse |
| div_cfg | input | 18 | Division ratio, 10 integer and 8 fraction bits |
| res_bits | input | 5 | Counter range as a power of two |
| pause | input | 1 | Hold counter and prescaler |
| cnt_clr | input | 1 | Synchronous clear of counter and prescaler |
| cnt_val | output | 20 | Current counter value |
| period_stb | output | 1 | Wrap strobe for channels |
| ovf_irq | output | 1 | Raw overflow interrupt pulse |

## Verification
The bench targets the following corner cases, and what a faulty design would show in each:

- **Fractional ratios 2.5 and 1.25.** A prescaler that ignored the carry, or applied it to the wrong period, would be off by one count at a known tick.
- **Zero integer part.** A divider that took the zero literally would stall the counter.
- **Pause with a partial prescaler period.** A design that reset the phase on pause would add a visible extra delay after resume.
- **Range lowered below the live count.** An equality-only wrap test would run on toward the 20-bit limit instead of wrapping.
- **Other boundaries.** The bench also checks R=0, a clamped R of 31, and a clear issued while paused.

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int CNT_W  = 20,
  parameter int DIV_W  = 18,
  parameter int FRAC_W = 8,
  parameter int RES_W  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_fast,
  input  logic             ref_tick,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [RES_W-1:0] res_bits,
  input  logic             pause,
  input  logic             cnt_clr,
  output logic [CNT_W-1:0] cnt_val,
  output logic             period_stb,
  output logic             ovf_irq
);
  localparam int INT_W = DIV_W - FRAC_W;
  localparam int LIM_W = INT_W + 1;

  logic [LIM_W-1:0]  phase_q;
  logic [FRAC_W-1:0] acc_q;
  logic              ext_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              stb_q;

  wire [INT_W-1:0]  int_part = div_cfg[DIV_W-1:FRAC_W];
  wire [FRAC_W-1:0] frac     = div_cfg[FRAC_W-1:0];
  wire [LIM_W-1:0]  int_eff  = (int_part == '0) ? LIM_W'(1) : {1'b0, int_part};
  wire [LIM_W-1:0]  lim      = int_eff + LIM_W'(ext_q);
  wire              last     = phase_q >= lim - LIM_W'(1);
  wire              tick     = src_fast | ref_tick;
  wire              adv      = tick & ~pause & ~cnt_clr;

  logic              carry;
  logic [FRAC_W-1:0] acc_sum;
  assign {carry, acc_sum} = {1'b0, acc_q} + {1'b0, frac};

  wire [RES_W-1:0] res_eff = (res_bits > RES_W'(CNT_W)) ? RES_W'(CNT_W) : res_bits;
  wire [CNT_W:0]   span    = {{CNT_W{1'b0}}, 1'b1} << res_eff;
  wire [CNT_W-1:0] term    = CNT_W'(span - 1'b1);
  wire             wrap    = cnt_q >= term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      acc_q   <= '0;
      ext_q   <= 1'b0;
      cnt_q   <= '0;
      stb_q   <= 1'b0;
    end else if (cnt_clr) begin
      phase_q <= '0;
      acc_q   <= '0;
      ext_q   <= 1'b0;
      cnt_q   <= '0;
      stb_q   <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      if (adv) begin
        if (last) begin
          phase_q <= '0;
          acc_q   <= acc_sum;
          ext_q   <= carry;
          if (wrap) begin
            cnt_q <= '0;
            stb_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end else begin
          phase_q <= phase_q + 1'b1;
        end
      end
    end
  end

  assign cnt_val    = cnt_q;
  assign period_stb = stb_q;
  assign ovf_irq    = stb_q;

  a_r1_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!src_fast && !ref_tick && !cnt_clr) |=> (cnt_q == $past(cnt_q)));

  a_r4_pause_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pause && !cnt_clr) |=> (cnt_q == $past(cnt_q) && !stb_q));

  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clr |=> (cnt_q == '0 && !stb_q));

  a_r7_stb_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> (cnt_q == '0));

  a_r6_step_rule: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1 || cnt_q == '0));
endmodule

// File: tb/sim_pwm_timebase.sv
module sim_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        src_fast = 1'b1;
  logic        ref_tick = 1'b0;
  logic [17:0] div_cfg = 18'h00100;
  logic [4:0]  res_bits = 5'd4;
  logic        pause = 1'b0;
  logic        cnt_clr = 1'b0;
  logic [19:0] cnt_val;
  logic        period_stb;
  logic        ovf_irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pwm_timebase u0 (
    .clk(clk), .rst_n(rst_n), .src_fast(src_fast), .ref_tick(ref_tick),
    .div_cfg(div_cfg), .res_bits(res_bits), .pause(pause), .cnt_clr(cnt_clr),
    .cnt_val(cnt_val), .period_stb(period_stb), .ovf_irq(ovf_irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic restart(input logic [17:0] d, input logic [4:0] r);
    div_cfg = d; res_bits = r; src_fast = 1'b1; pause = 1'b0;
    cnt_clr = 1'b1; run(1); cnt_clr = 1'b0;
  endtask

  task automatic t_reset;
    chk("R9 cnt after reset", int'(cnt_val), 0);
    chk("R9 stb after reset", int'(period_stb), 0);
    chk("R9 irq after reset", int'(ovf_irq), 0);
  endtask

  task automatic t_integer;
    restart(18'h00300, 5'd10);
    run(30);
    chk("R2 div 3.0 after 30 ticks", int'(cnt_val), 10);
  endtask

  task automatic t_wrap;
    restart(18'h00100, 5'd4);
    run(15);
    chk("R6 top of range", int'(cnt_val), 15);
    chk("R7 no strobe before wrap", int'(period_stb), 0);
    run(1);
    chk("R6 wrapped value", int'(cnt_val), 0);
    chk("R7 period strobe at wrap", int'(period_stb), 1);
    chk("R7 irq at wrap", int'(ovf_irq), 1);
    run(1);
    chk("R7 strobe one cycle", int'(period_stb), 0);
    chk("R6 count after wrap", int'(cnt_val), 1);
  endtask

  task automatic t_fraction;
    restart(18'h00280, 5'd10);
    run(23);
    chk("R2 div 2.5 at tick 23", int'(cnt_val), 9);
    run(1);
    chk("R2 div 2.5 at tick 24", int'(cnt_val), 10);
    restart(18'h00140, 5'd10);
    run(5);
    chk("R2 div 1.25 long period", int'(cnt_val), 4);
    run(5);
    chk("R2 div 1.25 at tick 10", int'(cnt_val), 8);
  endtask

  task automatic t_zero_int;
    restart(18'h00000, 5'd10);
    run(5);
    chk("R3 zero integer acts as one", int'(cnt_val), 5);
  endtask

  task automatic t_ref;
    restart(18'h00200, 5'd10);
    src_fast = 1'b0;
    run(20);
    chk("R1 no ref tick holds", int'(cnt_val), 0);
    for (int i = 0; i < 6; i++) begin
      ref_tick = 1'b1; run(1); ref_tick = 1'b0; run(3);
    end
    chk("R1 six ref ticks div 2", int'(cnt_val), 3);
    src_fast = 1'b1;
  endtask

  task automatic t_pause;
    restart(18'h00300, 5'd10);
    run(4);
    chk("R4 before pause", int'(cnt_val), 1);
    pause = 1'b1; run(10);
    chk("R4 held during pause", int'(cnt_val), 1);
    pause = 1'b0; run(2);
    chk("R4 phase kept across pause", int'(cnt_val), 2);
    run(3);
    pause = 1'b1; cnt_clr = 1'b1; run(1);
    chk("R5 clear wins over pause", int'(cnt_val), 0);
    chk("R5 no strobe on clear", int'(period_stb), 0);
    cnt_clr = 1'b0; pause = 1'b0;
  endtask

  task automatic t_res_edges;
    restart(18'h00100, 5'd0);
    run(3);
    chk("R6 R=0 stays zero", int'(cnt_val), 0);
    chk("R6 R=0 strobes each step", int'(period_stb), 1);
    restart(18'h00100, 5'd31);
    run(40);
    chk("R6 R=31 clamps, no early wrap", int'(cnt_val), 40);
    res_bits = 5'd3;
    run(1);
    chk("R8 lowered range wraps", int'(cnt_val), 0);
    chk("R8 strobe on forced wrap", int'(ovf_irq), 1);
  endtask

  initial begin
    run(2);
    t_reset();
    rst_n = 1'b1;
    run(1);
    t_integer();
    t_wrap();
    t_fraction();
    t_zero_int();
    t_ref();
    t_pause();
    t_res_edges();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule